// File: doc/BRIEF.md
# Combinational Programmable Sum-of-Products Core

This block is a field-configurable logic core. It takes twelve dedicated inputs and drives ten outputs. Each output has its own three-state driver. A programmable AND plane forms product terms from every dedicated input and from eight pin feedback signals, in true and inverted form. Each output then ORs three of those terms, inverts the result and drives it onto its pin. A fourth term per output decides whether that pin is driven. The first eight outputs are bidirectional. When one of them is not driven, the surrounding logic supplies its level on `pin_ext`, and that level enters the AND plane, so the pin works as an extra input. Outputs 8 and 9 have no feedback path.

The connection pattern sits in a bank of configuration rows, one row per product term, each one column wide per AND-plane input. Rows are written one at a time through a synchronous write port and can be read back combinationally. A sticky security bit, set by a single pulse, blanks the readback until the next reset. The logic path from `dat_in`/`pin_ext` to `pin_out`/`pin_oe` is purely combinational. Chains of feedback between bidirectional cells resolve within the same cycle.

Top module: `pal_comb_core`

## Requirements
- R1: After a synchronous active-low reset every configuration bit reads 1, the security bit is clear, every `pin_oe` bit is 0 and every `pin_out` bit is 1.
- R2: AND-plane signal s sits on column 2s in true form and on column 2s+1 inverted. Signals 0..11 are `dat_in[0..11]` and signals 12..19 are the feedback of bidirectional outputs 0..7. A configuration bit of 1 connects its column. A product term is the AND of its connected columns, and a term with no connected column is 1.
- R3: A product term that connects both columns of the same signal is 0 whatever that signal's level.
- R4: Output k uses rows 4k (enable) and 4k+1, 4k+2, 4k+3 (sum terms). `pin_out[k]` is the inverse of the OR of its three sum terms.
- R5: `pin_oe[k]` equals output k's enable term, evaluated in the same cycle.
- R6: For a bidirectional output j, the feedback signal equals `pin_ext[j]` while `pin_oe[j]` is 0. It equals `pin_out[j]` while `pin_oe[j]` is 1, and `pin_ext[j]` is then ignored.
- R7: An acyclic chain of feedback that runs through all eight bidirectional cells settles to its final value without any clock edge.
- R8: With `cfg_we` high at a rising edge, `cfg_wdata` replaces row `cfg_row`, and the change shows on the outputs after that edge. A write to a row number of 40 or above changes no row.
- R9: `cfg_rd_data` shows row `cfg_rd_row` combinationally, and shows 0 for row numbers of 40 or above.
- R10: A high `cfg_lock` at a rising edge sets the security bit. While it is set `cfg_rd_data` is 0, writes still take effect, and only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Row write strobe |
| cfg_row | input | 6 | Row number to write |
| cfg_wdata | input | 40 | Connection pattern for the written row |
| cfg_lock | input | 1 | Sets the sticky security bit |
| cfg_rd_row | input | 6 | Row number to read back |
| cfg_rd_data | output | 40 | Readback data, 0 when secured or out of range |
| dat_in | input | 12 | Dedicated logic inputs |
| pin_ext | input | 8 | Externally applied level on bidirectional pins 0..7 |
| pin_out | output | 10 | Inverted sum-of-products value per output |
| pin_oe | output | 10 | Driver enable per output, from its enable term |

## Verification
The functions that collide are the enable term and the feedback path. In one cycle a term can switch a bidirectional driver on or off and also pick whether a second cell sees the driven value or the external one. The bench provokes this with output 1, enabled by `dat_in[3]`, which feeds output 4. `dat_in[3]` is toggled while `pin_ext[1]` is held opposite to output 1's driven value. Each result is judged against the value R6 predicts for that enable state. An eight-deep inverter chain across all bidirectional cells checks that settling needs no clock edge.

// File: rtl/pal_pkg.sv
// Shared sizing for the programmable sum-of-products core.
// Assumes every output has the same number of sum terms plus one enable term.
package pal_pkg;
    localparam int unsigned PAL_DED  = 12; // dedicated inputs
    localparam int unsigned PAL_FB   = 8;  // bidirectional outputs with feedback
    localparam int unsigned PAL_OUTS = 10; // all outputs
    localparam int unsigned PAL_SUMS = 3;  // sum terms per output
    localparam int unsigned PAL_SIG  = PAL_DED + PAL_FB;
    localparam int unsigned PAL_COL  = 2 * PAL_SIG;
    localparam int unsigned PAL_RPO  = PAL_SUMS + 1;
    localparam int unsigned PAL_ROW  = PAL_OUTS * PAL_RPO;
endpackage

// File: rtl/pal_fuse_store.sv
// Configuration row bank with a write port, combinational readback and a
// sticky security bit. Assumes synchronous active-low reset; reset connects
// every column so that all terms read 0 and all drivers start disabled.
module pal_fuse_store #(
    parameter int unsigned N_ROW = 40,
    parameter int unsigned N_COL = 40,
    localparam int unsigned ROW_W = $clog2(N_ROW)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ROW_W-1:0]       wr_row,
    input  logic [N_COL-1:0]       wr_data,
    input  logic                   lock_set,
    input  logic [ROW_W-1:0]       rd_row,
    output logic [N_COL-1:0]       rd_data,
    output logic [N_ROW*N_COL-1:0] fuse_flat
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(N_ROW - 1);

    logic [N_COL-1:0] fuse_q [N_ROW];
    logic             lock_q;

    // Row storage: reset to fully connected, then one row per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < int'(N_ROW); r++) begin
                fuse_q[r] <= '1;
            end
        end else if (wr_en && (wr_row <= LAST_ROW)) begin
            fuse_q[wr_row] <= wr_data;
        end
    end

    // Security bit: set by a pulse, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (lock_set) begin
            lock_q <= 1'b1;
        end
    end

    // Readback mux: blank when secured or when the row does not exist.
    always_comb begin
        if (lock_q || (rd_row > LAST_ROW)) begin
            rd_data = '0;
        end else begin
            rd_data = fuse_q[rd_row];
        end
    end

    // Flatten the rows for the evaluation logic.
    for (genvar r = 0; r < int'(N_ROW); r++) begin : g_flat
        assign fuse_flat[r*N_COL +: N_COL] = fuse_q[r];
    end

    // R10: once secured, stays secured until reset.
    p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    // R8: an in-range write is held by the addressed row afterwards.
    p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_row <= LAST_ROW)) |=> (fuse_q[$past(wr_row)] == $past(wr_data)));
endmodule

// File: rtl/pal_settle.sv
// Resolves the feedback columns of the bidirectional cells without a clock.
// The AND plane of those cells is evaluated N_PASSES times in one
// combinational block; each pass updates every feedback bit from the pass
// before. Assumes the feedback graph is acyclic with depth below N_PASSES;
// a looped configuration yields the state after the last pass.
module pal_settle #(
    parameter int unsigned N_DED    = 12,
    parameter int unsigned N_FB     = 8,
    parameter int unsigned N_SUMS   = 3,
    parameter int unsigned N_PASSES = 9,
    localparam int unsigned N_SIG   = N_DED + N_FB,
    localparam int unsigned N_COL   = 2 * N_SIG,
    localparam int unsigned RPO     = N_SUMS + 1
) (
    input  logic [N_FB*RPO*N_COL-1:0] fuse_flat,
    input  logic [N_DED-1:0]          ded_in,
    input  logic [N_FB-1:0]           fb_ext,
    output logic [N_COL-1:0]          cols
);
    // Expand signals into true/complement column pairs.
    function automatic logic [N_COL-1:0] spread(input logic [N_SIG-1:0] s);
        logic [N_COL-1:0] c;
        for (int i = 0; i < int'(N_SIG); i++) begin
            c[2*i]   = s[i];
            c[2*i+1] = ~s[i];
        end
        return c;
    endfunction

    // AND of the connected columns; an empty row yields 1.
    function automatic logic term(input logic [N_COL-1:0] f,
                                  input logic [N_COL-1:0] c);
        return &(~f | c);
    endfunction

    // Fixed-count relaxation of the feedback bits.
    always_comb begin : settle_proc
        logic [N_FB-1:0]  fb_v;
        logic [N_FB-1:0]  nxt_v;
        logic [N_COL-1:0] col_v;
        logic             en_v;
        logic             any_v;
        fb_v  = fb_ext;
        nxt_v = fb_ext;
        for (int p = 0; p < int'(N_PASSES); p++) begin
            col_v = spread({fb_v, ded_in});
            for (int k = 0; k < int'(N_FB); k++) begin
                en_v  = term(fuse_flat[(k*RPO)*N_COL +: N_COL], col_v);
                any_v = 1'b0;
                for (int t = 1; t < int'(RPO); t++) begin
                    any_v = any_v | term(fuse_flat[(k*RPO+t)*N_COL +: N_COL], col_v);
                end
                nxt_v[k] = en_v ? ~any_v : fb_ext[k];
            end
            fb_v = nxt_v;
        end
        cols = spread({fb_v, ded_in});
    end
endmodule

// File: rtl/pal_macrocell.sv
// One output cell: an enable term, a fixed OR of the sum terms and an
// inverting driver. Assumes row 0 of its slice is the enable term and rows
// 1..N_SUMS are the sum terms.
module pal_macrocell #(
    parameter int unsigned N_COL  = 40,
    parameter int unsigned N_SUMS = 3,
    localparam int unsigned RPO   = N_SUMS + 1,
    localparam int unsigned N_SIG = N_COL / 2
) (
    input  logic [RPO*N_COL-1:0] fuse_rows,
    input  logic [N_COL-1:0]     cols,
    output logic                 drv,
    output logic                 oe
);
    logic [RPO-1:0] terms;

    // Product terms of this cell.
    for (genvar t = 0; t < int'(RPO); t++) begin : g_term
        assign terms[t] = &(~fuse_rows[t*N_COL +: N_COL] | cols);
    end

    // Enable term and inverted sum.
    assign oe  = terms[0];
    assign drv = ~(|terms[RPO-1:1]);

    // Term-level invariants from the connection pattern.
    always_comb begin
        for (int t = 0; t < int'(RPO); t++) begin
            if (fuse_rows[t*N_COL +: N_COL] == '0) begin
                p_empty_term_true_r2: assert (terms[t]);
            end
            for (int s = 0; s < int'(N_SIG); s++) begin
                if (fuse_rows[t*N_COL + 2*s] && fuse_rows[t*N_COL + 2*s + 1]) begin
                    p_contradict_false_r3: assert (!terms[t]);
                end
            end
        end
    end
endmodule

// File: rtl/pal_comb_core.sv
// Top of the programmable sum-of-products core. Ties the configuration
// store, the feedback settle logic and one output cell per output.
// Assumes N_FB <= N_OUTS: the first N_FB outputs carry feedback.
module pal_comb_core
    import pal_pkg::*;
#(
    parameter int unsigned N_DED    = PAL_DED,
    parameter int unsigned N_FB     = PAL_FB,
    parameter int unsigned N_OUTS   = PAL_OUTS,
    parameter int unsigned N_SUMS   = PAL_SUMS,
    parameter int unsigned N_PASSES = PAL_FB + 1,
    localparam int unsigned N_SIG   = N_DED + N_FB,
    localparam int unsigned N_COL   = 2 * N_SIG,
    localparam int unsigned RPO     = N_SUMS + 1,
    localparam int unsigned N_ROW   = N_OUTS * RPO,
    localparam int unsigned ROW_W   = $clog2(N_ROW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ROW_W-1:0]  cfg_row,
    input  logic [N_COL-1:0]  cfg_wdata,
    input  logic              cfg_lock,
    input  logic [ROW_W-1:0]  cfg_rd_row,
    output logic [N_COL-1:0]  cfg_rd_data,
    input  logic [N_DED-1:0]  dat_in,
    input  logic [N_FB-1:0]   pin_ext,
    output logic [N_OUTS-1:0] pin_out,
    output logic [N_OUTS-1:0] pin_oe
);
    logic [N_ROW*N_COL-1:0] fuse_flat;
    logic [N_COL-1:0]       cols;

    pal_fuse_store #(
        .N_ROW (N_ROW),
        .N_COL (N_COL)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_row    (cfg_row),
        .wr_data   (cfg_wdata),
        .lock_set  (cfg_lock),
        .rd_row    (cfg_rd_row),
        .rd_data   (cfg_rd_data),
        .fuse_flat (fuse_flat)
    );

    pal_settle #(
        .N_DED    (N_DED),
        .N_FB     (N_FB),
        .N_SUMS   (N_SUMS),
        .N_PASSES (N_PASSES)
    ) u_settle (
        .fuse_flat (fuse_flat[N_FB*RPO*N_COL-1:0]),
        .ded_in    (dat_in),
        .fb_ext    (pin_ext),
        .cols      (cols)
    );

    for (genvar k = 0; k < int'(N_OUTS); k++) begin : g_cell
        pal_macrocell #(
            .N_COL  (N_COL),
            .N_SUMS (N_SUMS)
        ) u_cell (
            .fuse_rows (fuse_flat[k*RPO*N_COL +: RPO*N_COL]),
            .cols      (cols),
            .drv       (pin_out[k]),
            .oe        (pin_oe[k])
        );
    end

    // R10: the edge after a lock request sees a blank readback.
    p_secure_hides_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_lock |=> (cfg_rd_data == '0));
endmodule

// File: tb/pal_comb_core_test.sv
`timescale 1ns/1ps
module pal_comb_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_row = '0;
    logic [39:0] cfg_wdata = '0;
    logic        cfg_lock = 1'b0;
    logic [5:0]  cfg_rd_row = '0;
    logic [39:0] cfg_rd_data;
    logic [11:0] dat_in = '0;
    logic [7:0]  pin_ext = '0;
    logic [9:0]  pin_out;
    logic [9:0]  pin_oe;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [39:0] ONES = '1;

    typedef struct packed {
        logic [11:0] din;
        logic [7:0]  ext;
        logic [9:0]  exp_out;
        logic [9:0]  exp_oe;
    } vec_t;

    // Stimulus and expected results under configuration A (see below).
    localparam vec_t VEC [8] = '{
        '{12'h000, 8'h00, 10'h1FD, 10'h319},
        '{12'h003, 8'h00, 10'h1FE, 10'h319},
        '{12'h009, 8'h06, 10'h1F5, 10'h31B},
        '{12'h00C, 8'h00, 10'h1EE, 10'h31B},
        '{12'h004, 8'h02, 10'h1EE, 10'h319},
        '{12'h090, 8'hFF, 10'h0E5, 10'h119},
        '{12'h070, 8'h00, 10'h1FD, 10'h319},
        '{12'hFFF, 8'hFF, 10'h1E6, 10'h11B}
    };

    pal_comb_core uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_row     (cfg_row),
        .cfg_wdata   (cfg_wdata),
        .cfg_lock    (cfg_lock),
        .cfg_rd_row  (cfg_rd_row),
        .cfg_rd_data (cfg_rd_data),
        .dat_in      (dat_in),
        .pin_ext     (pin_ext),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe)
    );

    always #2.5 clk = ~clk;

    function automatic logic [39:0] ct(input int s);
        return 40'd1 << (2 * s);
    endfunction

    function automatic logic [39:0] cc(input int s);
        return 40'd1 << (2 * s + 1);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int row, input logic [39:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_row = row[5:0];
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drive(input logic [11:0] d, input logic [7:0] e);
        @(negedge clk);
        dat_in = d;
        pin_ext = e;
        #1;
    endtask

    task automatic rd(input int row);
        @(negedge clk);
        cfg_rd_row = row[5:0];
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        drive(12'h000, 8'h00);
        chk("R1 oe after reset", 64'(pin_oe), 64'h000);
        chk("R1 out after reset", 64'(pin_out), 64'h3FF);
        rd(0);
        chk("R1 row0 readback", 64'(cfg_rd_data), 64'(ONES));

        // Configuration A
        wr(0, 40'd0);
        wr(1, ct(0) | ct(1));
        wr(2, ct(2));
        wr(4, ct(3));
        wr(5, ct(12));
        wr(12, 40'd0);
        wr(13, ct(14));
        wr(16, 40'd0);
        wr(17, ct(13));
        wr(32, 40'd0);
        wr(33, ct(4) | cc(5));
        wr(34, ct(6) | cc(6));
        wr(36, cc(7));
        wr(37, 40'd0);

        // R2 R3 R4 R5 R6: vector table
        for (int i = 0; i < 8; i++) begin
            drive(VEC[i].din, VEC[i].ext);
            chk($sformatf("R4 R6 out vec %0d", i), 64'(pin_out), 64'(VEC[i].exp_out));
            chk($sformatf("R5 oe vec %0d", i), 64'(pin_oe), 64'(VEC[i].exp_oe));
        end

        // R9 readback
        rd(1);
        chk("R9 row1 readback", 64'(cfg_rd_data), 64'h5);
        rd(33);
        chk("R9 row33 readback", 64'(cfg_rd_data), 64'h900);
        rd(45);
        chk("R9 row45 readback", 64'(cfg_rd_data), 64'h0);

        // R8: out-of-range write changes no row
        wr(45, 40'd0);
        rd(5);
        chk("R8 row5 after bad write", 64'(cfg_rd_data), 64'(ct(12)));
        drive(12'h003, 8'h00);
        chk("R8 out after bad write", 64'(pin_out), 64'h1FE);

        // R7: eight-deep feedback chain
        for (int k = 0; k < 8; k++) begin
            wr(4 * k, 40'd0);
            wr(4 * k + 1, (k == 0) ? ct(0) : ct(12 + k - 1));
            wr(4 * k + 2, ONES);
            wr(4 * k + 3, ONES);
        end
        drive(12'h001, 8'hFF);
        chk("R7 chain out high", 64'(pin_out), 64'h1AA);
        chk("R7 chain oe", 64'(pin_oe), 64'h3FF);
        drive(12'h000, 8'h00);
        chk("R7 chain out low", 64'(pin_out), 64'h155);

        // R10: security
        @(negedge clk);
        cfg_lock = 1'b1;
        @(negedge clk);
        cfg_lock = 1'b0;
        rd(1);
        chk("R10 readback blanked", 64'(cfg_rd_data), 64'h0);
        wr(37, ONES);
        drive(12'h000, 8'h00);
        chk("R10 write while secured", 64'(pin_out[9]), 64'h1);
        rd(0);
        chk("R10 still blanked", 64'(cfg_rd_data), 64'h0);

        // R1 R10: reset clears security and restores defaults
        do_reset();
        rd(0);
        chk("R10 R1 readback after reset", 64'(cfg_rd_data), 64'(ONES));
        drive(12'hFFF, 8'hFF);
        chk("R1 oe after second reset", 64'(pin_oe), 64'h000);
        chk("R1 out after second reset", 64'(pin_out), 64'h3FF);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule